// File: doc/BRIEF.md
# Header and Signature Rule Correlator

This block decides, flow by flow, which detection rules have fully matched. Upstream engines report match identifiers on one input stream: header identifiers from packet classification and content identifiers from signature scanners, plus end-of-packet and end-of-flow markers. A rule is made of one header identifier and zero or more content identifiers. A rule fires once its header has been seen in the flow and each of its signatures has been seen at least once. The rules that fire inside one packet are gathered into a single alert word. That word is handed out when the packet ends.

Internally the block keeps two presence bit-vectors, one for contents and one for headers. It also keeps a linked-list reverse index from content to rules, a rule-to-header map, per-rule required counts with running counts, and per-rule lists of signature identifiers so that a firing rule can re-arm itself. Software fills all tables through a plain write port. The identifier input and the alert output are valid/ready streams. The input is held off, never dropped, while the list walk is in progress or an alert is waiting. The alert is held stable until it is taken.

Top module: `rule_correlator`

## Requirements
- R1: After reset `id_ready` is 1, `alert_valid` is 0, `alert_mask` is all zero, both presence vectors are empty and all running counts are zero.
- R2: An identifier is taken on a clock edge where `id_valid` and `id_ready` are both 1. `id_kind` encodes the identifier: 0 content, 1 header, 2 end of packet, 3 end of flow. `id_ready` is 0 whenever a list walk or its last rule check is in progress, and whenever an alert is pending.
- R3: A content identifier whose presence bit is clear sets that bit and starts a list walk. If the bit is already set, the identifier is discarded, no walk starts and `id_ready` stays 1.
- R4: The walk starts at node number equal to the content identifier. It yields one rule per cycle and follows next pointers until an entry has no valid next pointer. For a list of n entries, `id_ready` is 0 for exactly n+1 cycles after the accepting edge.
- R5: A rule yielded by the walk is dropped when the presence bit of its mapped header identifier is clear.
- R6: A surviving rule increments its running count. It fires when the incremented count equals its programmed required count (1 to 15). Firing sets bit `rid` of the pending alert word.
- R7: When a rule fires, its running count returns to zero and the presence bits of the signature identifiers stored in its first `required` slots are cleared, so the same rule can fire again in the same flow.
- R8: A header identifier h with h >= `HO_BASE` (default 224) marks rule h-`HO_BASE` as fired without any content.
- R9: On an accepted end-of-packet marker with a non-empty pending word, `alert_valid` becomes 1 on that edge and `alert_mask` shows the word. If the word is empty, no alert is raised.
- R10: While `alert_valid` is 1 and `alert_ready` is 0, `alert_valid` and `alert_mask` hold. On the handshake edge the alert drops and the pending word is cleared.
- R11: An end-of-flow marker raises an alert as in R9. It also clears both presence vectors and all running counts.
- R12: Programming writes when `prog_en` is 1. `prog_sel` selects the table. Select 0 writes list node `prog_addr[10:0]`: rule in data[6:0], entry valid in data[16], next valid in data[17], next node in data[30:20]. Select 1 writes the header of rule `prog_addr[6:0]` from data[7:0]. Select 2 writes its required count from data[3:0]. Select 3 writes signature slot `prog_addr[3:0]` (0 to 14) of rule `prog_addr[10:4]` from data[9:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Identifier stream valid |
| id_ready | output | 1 | Identifier stream ready |
| id_kind | input | 2 | 0 content, 1 header, 2 end of packet, 3 end of flow |
| id_value | input | 10 | Identifier value |
| alert_valid | output | 1 | Alert word valid |
| alert_ready | input | 1 | Alert word accepted |
| alert_mask | output | 128 | One bit per fired rule |
| prog_en | input | 1 | Table write strobe |
| prog_sel | input | 2 | Table select |
| prog_addr | input | 16 | Table address |
| prog_data | input | 32 | Table write data |

## Verification
A fresh content identifier occupies the block for n+1 cycles for a list of n entries. The last rule check lands on the final edge of that window. A header identifier, including a header-only one, takes effect on its accepting edge. An alert is visible directly after the edge that takes the packet or flow marker. The bench drives on falling edges and waits for `id_ready` before each marker. It therefore samples `alert_valid` at the first falling edge after the marker is taken. It counts the falling edges with `id_ready` low after a content identifier to check the n+1 window exactly.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    K_CID = 2'd0,
    K_HID = 2'd1,
    K_EOP = 2'd2,
    K_EOF = 2'd3
  } id_kind_e;

  typedef enum logic [1:0] {
    T_NODE = 2'd0,
    T_HMAP = 2'd1,
    T_REQ  = 2'd2,
    T_SLOT = 2'd3
  } tbl_sel_e;

  localparam int CNT_W        = 4;
  localparam int MAX_SIG      = 15;
  localparam int SLOT_W       = 4;
  localparam int NODE_VLD_BIT = 16;
  localparam int NEXT_VLD_BIT = 17;
  localparam int NEXT_LSB     = 20;
endpackage

// File: rtl/rc_tables.sv
module rc_tables
  import rc_pkg::*;
#(
  parameter int N_CID  = 1024,
  parameter int N_HID  = 256,
  parameter int N_RID  = 128,
  parameter int N_NODE = 2048
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       prog_en,
  input  logic [1:0]                 prog_sel,
  input  logic [15:0]                prog_addr,
  input  logic [31:0]                prog_data,
  input  logic [$clog2(N_NODE)-1:0]  node_addr,
  output logic [$clog2(N_RID)-1:0]   node_rid,
  output logic                       node_vld,
  output logic                       node_nv,
  output logic [$clog2(N_NODE)-1:0]  node_nxt,
  input  logic [$clog2(N_RID)-1:0]   rule_addr,
  output logic [$clog2(N_HID)-1:0]   rule_hid,
  output logic [CNT_W-1:0]           rule_req,
  output logic [MAX_SIG*$clog2(N_CID)-1:0] rule_slots
);
  localparam int CID_W  = $clog2(N_CID);
  localparam int HID_W  = $clog2(N_HID);
  localparam int RID_W  = $clog2(N_RID);
  localparam int NODE_W = $clog2(N_NODE);

  logic              vld_q  [N_NODE];
  logic              nv_q   [N_NODE];
  logic [RID_W-1:0]  rid_q  [N_NODE];
  logic [NODE_W-1:0] nxt_q  [N_NODE];
  logic [HID_W-1:0]  hmap_q [N_RID];
  logic [CNT_W-1:0]  req_q  [N_RID];
  logic [CID_W-1:0]  slot_q [N_RID][MAX_SIG];

  logic [NODE_W-1:0] w_node;
  logic [RID_W-1:0]  w_rule;
  logic [RID_W-1:0]  w_srule;
  logic [SLOT_W-1:0] w_slot;

  assign w_node  = prog_addr[NODE_W-1:0];
  assign w_rule  = prog_addr[RID_W-1:0];
  assign w_slot  = prog_addr[SLOT_W-1:0];
  assign w_srule = prog_addr[SLOT_W +: RID_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_NODE; i++) vld_q[i] <= 1'b0;
      for (int i = 0; i < N_RID; i++) req_q[i] <= '0;
    end else if (prog_en) begin
      if (prog_sel == T_NODE) vld_q[w_node] <= prog_data[NODE_VLD_BIT];
      if (prog_sel == T_REQ)  req_q[w_rule] <= prog_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (prog_en) begin
      case (prog_sel)
        T_NODE: begin
          nv_q[w_node]  <= prog_data[NEXT_VLD_BIT];
          rid_q[w_node] <= prog_data[RID_W-1:0];
          nxt_q[w_node] <= prog_data[NEXT_LSB +: NODE_W];
        end
        T_HMAP: hmap_q[w_rule] <= prog_data[HID_W-1:0];
        T_SLOT: if (int'(w_slot) < MAX_SIG) slot_q[w_srule][w_slot] <= prog_data[CID_W-1:0];
        default: ;
      endcase
    end
  end

  assign node_vld = vld_q[node_addr];
  assign node_nv  = nv_q[node_addr];
  assign node_rid = rid_q[node_addr];
  assign node_nxt = nxt_q[node_addr];
  assign rule_hid = hmap_q[rule_addr];
  assign rule_req = req_q[rule_addr];

  for (genvar s = 0; s < MAX_SIG; s++) begin : g_slot
    assign rule_slots[s*CID_W +: CID_W] = slot_q[rule_addr][s];
  end

  logic unused_prog;
  assign unused_prog = ^{prog_addr, prog_data};
endmodule

// File: rtl/rc_walker.sv
module rc_walker #(
  parameter int N_RID  = 128,
  parameter int N_NODE = 2048
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(N_NODE)-1:0]  start_ptr,
  output logic [$clog2(N_NODE)-1:0]  node_addr,
  input  logic                       node_vld,
  input  logic                       node_nv,
  input  logic [$clog2(N_RID)-1:0]   node_rid,
  input  logic [$clog2(N_NODE)-1:0]  node_nxt,
  output logic                       busy,
  output logic                       emit_valid,
  output logic [$clog2(N_RID)-1:0]   emit_rid
);
  localparam int NODE_W = $clog2(N_NODE);

  logic [NODE_W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      emit_valid <= 1'b0;
      emit_rid   <= '0;
      cur_q      <= '0;
    end else begin
      emit_valid <= 1'b0;
      if (busy) begin
        emit_valid <= node_vld;
        emit_rid   <= node_rid;
        if (node_vld && node_nv) cur_q <= node_nxt;
        else busy <= 1'b0;
      end else if (start) begin
        busy  <= 1'b1;
        cur_q <= start_ptr;
      end
    end
  end

  assign node_addr = cur_q;
endmodule

// File: rtl/rc_judge.sv
module rc_judge
  import rc_pkg::*;
#(
  parameter int N_HID = 256,
  parameter int N_RID = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flow_clr,
  input  logic                      in_valid,
  input  logic [$clog2(N_RID)-1:0]  in_rid,
  input  logic [$clog2(N_HID)-1:0]  rule_hid,
  input  logic [CNT_W-1:0]          rule_req,
  input  logic [N_HID-1:0]          hid_bits,
  output logic                      hit,
  output logic                      fire
);
  logic [CNT_W-1:0] cnt_q [N_RID];
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q[in_rid] + 1'b1;
  assign hit     = in_valid && hid_bits[rule_hid];
  assign fire    = hit && (cnt_inc == rule_req);

  always_ff @(posedge clk) begin
    if (!rst_n || flow_clr) begin
      for (int i = 0; i < N_RID; i++) cnt_q[i] <= '0;
    end else if (hit) begin
      cnt_q[in_rid] <= fire ? '0 : cnt_inc;
    end
  end
endmodule

// File: rtl/rule_correlator.sv
module rule_correlator
  import rc_pkg::*;
#(
  parameter int N_CID   = 1024,
  parameter int N_HID   = 256,
  parameter int N_RID   = 128,
  parameter int N_NODE  = 2048,
  parameter int HO_BASE = 224,
  parameter int ID_W    = ($clog2(N_CID) > $clog2(N_HID)) ? $clog2(N_CID) : $clog2(N_HID)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  output logic             id_ready,
  input  logic [1:0]       id_kind,
  input  logic [ID_W-1:0]  id_value,
  output logic             alert_valid,
  input  logic             alert_ready,
  output logic [N_RID-1:0] alert_mask,
  input  logic             prog_en,
  input  logic [1:0]       prog_sel,
  input  logic [15:0]      prog_addr,
  input  logic [31:0]      prog_data
);
  localparam int CID_W  = $clog2(N_CID);
  localparam int HID_W  = $clog2(N_HID);
  localparam int RID_W  = $clog2(N_RID);
  localparam int NODE_W = $clog2(N_NODE);

  logic [N_CID-1:0] cid_bits;
  logic [N_HID-1:0] hid_bits;
  logic [N_RID-1:0] pend_q;

  logic             accept, walk_busy, emit_v, cid_new, cid_hit;
  logic             is_cid, is_hid, is_end, is_eof, ho_hit, match_fire, rule_hit;
  logic [CID_W-1:0] cid;
  logic [HID_W-1:0] hid, ho_off;
  logic [RID_W-1:0] ho_rid, emit_rid, node_rid;
  logic [NODE_W-1:0] node_addr, node_nxt;
  logic             node_vld, node_nv;
  logic [HID_W-1:0] rule_hid;
  logic [CNT_W-1:0] rule_req;
  logic [MAX_SIG*CID_W-1:0] rule_slots;
  logic             hid_any;

  assign id_ready = !walk_busy && !emit_v && !alert_valid;
  assign accept   = id_valid && id_ready;
  assign is_cid   = accept && (id_kind == K_CID);
  assign is_hid   = accept && (id_kind == K_HID);
  assign is_eof   = accept && (id_kind == K_EOF);
  assign is_end   = accept && ((id_kind == K_EOP) || (id_kind == K_EOF));
  assign cid      = id_value[CID_W-1:0];
  assign hid      = id_value[HID_W-1:0];
  assign cid_hit  = cid_bits[cid];
  assign cid_new  = is_cid && !cid_hit;
  assign ho_off   = hid - HID_W'(HO_BASE);
  assign ho_rid   = RID_W'(ho_off);
  assign ho_hit   = is_hid && (int'(hid) >= HO_BASE);
  assign hid_any  = |hid_bits;

  rc_tables #(.N_CID(N_CID), .N_HID(N_HID), .N_RID(N_RID), .N_NODE(N_NODE)) u_tables (
    .clk, .rst_n, .prog_en, .prog_sel, .prog_addr, .prog_data,
    .node_addr, .node_rid, .node_vld, .node_nv, .node_nxt,
    .rule_addr(emit_rid), .rule_hid, .rule_req, .rule_slots
  );

  rc_walker #(.N_RID(N_RID), .N_NODE(N_NODE)) u_walker (
    .clk, .rst_n, .start(cid_new), .start_ptr(NODE_W'(cid)),
    .node_addr, .node_vld, .node_nv, .node_rid, .node_nxt,
    .busy(walk_busy), .emit_valid(emit_v), .emit_rid
  );

  rc_judge #(.N_HID(N_HID), .N_RID(N_RID)) u_judge (
    .clk, .rst_n, .flow_clr(is_eof), .in_valid(emit_v), .in_rid(emit_rid),
    .rule_hid, .rule_req, .hid_bits, .hit(rule_hit), .fire(match_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || is_eof) begin
      cid_bits <= '0;
    end else begin
      if (cid_new) cid_bits[cid] <= 1'b1;
      if (match_fire) begin
        for (int s = 0; s < MAX_SIG; s++) begin
          if (CNT_W'(s) < rule_req) cid_bits[rule_slots[s*CID_W +: CID_W]] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || is_eof) hid_bits <= '0;
    else if (is_hid) hid_bits[hid] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= '0;
      alert_valid <= 1'b0;
    end else if (alert_valid && alert_ready) begin
      pend_q      <= '0;
      alert_valid <= 1'b0;
    end else begin
      if (ho_hit) pend_q[ho_rid] <= 1'b1;
      if (match_fire) pend_q[emit_rid] <= 1'b1;
      if (is_end && (pend_q != '0)) alert_valid <= 1'b1;
    end
  end

  assign alert_mask = pend_q;

  logic unused_top;
  assign unused_top = ^{id_value, rule_hit, ho_off};
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int N_RID = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             id_valid,
  input logic             id_ready,
  input logic [1:0]       id_kind,
  input logic             walk_busy,
  input logic             cid_hit,
  input logic             match_fire,
  input logic             hid_any,
  input logic             alert_valid,
  input logic             alert_ready,
  input logic [N_RID-1:0] alert_mask
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> id_ready && !alert_valid); // R1

  AST_ALERT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    alert_valid |-> !id_ready); // R2

  AST_DUP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_ready && id_kind == 2'd0 && cid_hit) |=> !walk_busy); // R3

  AST_WALK_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |-> !id_ready); // R4

  AST_FIRE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    match_fire |=> (alert_mask != '0)); // R6

  AST_ALERT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    alert_valid |-> (alert_mask != '0)); // R9

  AST_ALERT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_valid && !alert_ready) |=> (alert_valid && $stable(alert_mask))); // R10

  AST_EOF_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_ready && id_kind == 2'd3) |=> !hid_any); // R11
endmodule

bind rule_correlator rc_checker #(.N_RID(N_RID)) u_rc_checker (
  .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_ready(id_ready), .id_kind(id_kind),
  .walk_busy(walk_busy), .cid_hit(cid_hit), .match_fire(match_fire), .hid_any(hid_any),
  .alert_valid(alert_valid), .alert_ready(alert_ready), .alert_mask(alert_mask)
);

// File: tb/test_rule_correlator.sv
module test_rule_correlator;
  localparam int NR = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          id_valid = 1'b0;
  logic          id_ready;
  logic [1:0]    id_kind = 2'd0;
  logic [9:0]    id_value = '0;
  logic          alert_valid;
  logic          alert_ready = 1'b0;
  logic [NR-1:0] alert_mask;
  logic          prog_en = 1'b0;
  logic [1:0]    prog_sel = 2'd0;
  logic [15:0]   prog_addr = '0;
  logic [31:0]   prog_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rule_correlator i_rule_correlator (
    .clk, .rst_n, .id_valid, .id_ready, .id_kind, .id_value,
    .alert_valid, .alert_ready, .alert_mask,
    .prog_en, .prog_sel, .prog_addr, .prog_data
  );

  task automatic check(input bit ok, input string req, input logic [NR-1:0] act, input logic [NR-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [1:0] sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    prog_en = 1'b1; prog_sel = sel; prog_addr = 16'(addr); prog_data = data;
    @(negedge clk);
    prog_en = 1'b0;
  endtask

  // R12: node word = rid[6:0] | valid<<16 | next_valid<<17 | next<<20
  task automatic node(input int idx, input int rid, input bit nv, input int nxt);
    prog(2'd0, idx, 32'(rid) | (32'd1 << 16) | (32'(nv) << 17) | (32'(nxt) << 20));
  endtask

  task automatic rule(input int rid, input int hid, input int req);
    prog(2'd1, rid, 32'(hid));
    prog(2'd2, rid, 32'(req));
  endtask

  task automatic slot(input int rid, input int s, input int cidv);
    prog(2'd3, (rid << 4) | s, 32'(cidv));
  endtask

  task automatic send(input logic [1:0] k, input int v);
    @(negedge clk);
    id_valid = 1'b1; id_kind = k; id_value = 10'(v);
    while (!id_ready) @(negedge clk);
    @(negedge clk);
    id_valid = 1'b0;
  endtask

  function automatic logic [NR-1:0] bit_of(input int r);
    logic [NR-1:0] m = '0;
    m[r] = 1'b1;
    return m;
  endfunction

  // send a marker, check the alert one edge later, then take it
  task automatic close(input logic [1:0] k, input logic [NR-1:0] exp, input string req);
    send(k, 0);
    if (exp == '0) begin
      check(alert_valid == 1'b0, req, {127'd0, alert_valid}, '0);
    end else begin
      check(alert_valid == 1'b1 && alert_mask == exp, req, alert_mask, exp);
      alert_ready = 1'b1;
      @(negedge clk);
      alert_ready = 1'b0;
      check(alert_valid == 1'b0 && alert_mask == '0, "R10 handshake clears", alert_mask, '0);
    end
  endtask

  task automatic ready_window(input int exp_low, input string req);
    int low = 0;
    while (!id_ready && low < 50) begin low++; @(negedge clk); end
    check(low == exp_low, req, NR'(low), NR'(exp_low));
  endtask

  task automatic t_reset;
    check(id_ready == 1'b1 && alert_valid == 1'b0 && alert_mask == '0, "R1 reset state",
          {alert_mask[NR-1:2], id_ready, alert_valid}, 128'd2);
  endtask

  task automatic t_basic;
    send(2'd1, 3);
    send(2'd0, 100);
    ready_window(2, "R4 single entry window");
    send(2'd0, 100);
    check(id_ready == 1'b1, "R3 repeat discarded, no walk", {127'd0, id_ready}, 128'd1);
    close(2'd2, '0, "R3 repeat does not count");
    send(2'd0, 101);
    close(2'd2, bit_of(10), "R6 rule fires on last signature");
  endtask

  task automatic t_rearm;
    send(2'd0, 100);
    send(2'd0, 101);
    close(2'd2, bit_of(10), "R7 rule re-arms after firing");
  endtask

  task automatic t_multi;
    send(2'd1, 4);
    send(2'd0, 200);
    ready_window(3, "R4 two entry window");
    close(2'd2, bit_of(40) | bit_of(41), "R4 list yields both rules");
  endtask

  task automatic t_header_gate;
    send(2'd0, 300);
    close(2'd2, '0, "R5 rule dropped without header");
    close(2'd3, '0, "R11 empty flow end");
    send(2'd1, 9);
    send(2'd0, 300);
    close(2'd2, bit_of(50), "R5 rule kept with header");
  endtask

  task automatic t_header_only;
    send(2'd1, 229);
    check(id_ready == 1'b1, "R8 header-only needs no walk", {127'd0, id_ready}, 128'd1);
    close(2'd2, bit_of(5), "R8 header-only rule fires");
  endtask

  task automatic t_fifteen;
    send(2'd1, 5);
    for (int i = 0; i < 14; i++) send(2'd0, 400 + i);
    close(2'd2, '0, "R6 fourteen of fifteen");
    send(2'd0, 414);
    close(2'd2, bit_of(60), "R6 fifteen of fifteen");
  endtask

  task automatic t_flow_end;
    close(2'd3, '0, "R11 flow end");
    send(2'd1, 3);
    send(2'd0, 100);
    close(2'd3, '0, "R11 partial flow no alert");
    send(2'd1, 3);
    send(2'd0, 101);
    close(2'd2, '0, "R11 counts cleared at flow end");
    send(2'd1, 229);
    close(2'd3, bit_of(5), "R11 flow end raises alert");
  endtask

  task automatic t_backpressure;
    logic [NR-1:0] held;
    send(2'd1, 229);
    send(2'd2, 0);
    held = alert_mask;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(alert_valid && alert_mask == held && held == bit_of(5), "R10 alert held", alert_mask, bit_of(5));
      check(id_ready == 1'b0, "R2 input stalled while alert pending", {127'd0, id_ready}, '0);
    end
    alert_ready = 1'b1;
    @(negedge clk);
    alert_ready = 1'b0;
    check(alert_valid == 1'b0 && id_ready == 1'b1, "R10 released", {126'd0, alert_valid, id_ready}, 128'd1);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    // R12: table programming
    node(100, 10, 1'b0, 0); node(101, 10, 1'b0, 0);
    rule(10, 3, 2); slot(10, 0, 100); slot(10, 1, 101);
    node(200, 40, 1'b1, 1500); node(1500, 41, 1'b0, 0);
    rule(40, 4, 1); slot(40, 0, 200);
    rule(41, 4, 1); slot(41, 0, 200);
    node(300, 50, 1'b0, 0); rule(50, 9, 1); slot(50, 0, 300);
    rule(60, 5, 15);
    for (int i = 0; i < 15; i++) begin node(400 + i, 60, 1'b0, 0); slot(60, i, 400 + i); end
    t_basic();
    t_rearm();
    t_multi();
    close(2'd3, '0, "R11 flow end");
    t_header_gate();
    close(2'd3, '0, "R11 flow end");
    t_header_only();
    t_fifteen();
    t_flow_end();
    t_backpressure();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule